// File: doc/BRIEF.md
# Command-Driven Register-File Memory

This block is a small synchronous memory built entirely from flip-flops. It holds 2^ADDR_W words of DATA_W bits each. Every clock it accepts one packed request that carries a two-bit command, an address and a data word. The block is a finite-state machine. Its state is the word array, a registered copy of the request (command, address, data) and a registered output word. The output port is a plain wire view of that output register.

A request is captured on the first rising edge after it is presented. On the next edge the captured command is carried out. A store overwrites the addressed word. A fetch copies the addressed word into the output register. Every other code leaves the array and the output alone. Because execution always works on the captured copy, a store followed directly by a fetch of the same address returns the new data.

Top module: `cmdmem_top`

## Requirements
- R1: The request `req_i` is laid out with data in bits [DATA_W-1:0], address in bits [ADDR_W+DATA_W-1:DATA_W] and the command in the two top bits. Command code 2'b10 stores, 2'b01 fetches, 2'b00 is idle.
- R2: A store presented before rising edge k writes its data into the addressed word at edge k+1, so a later fetch of that address returns the data.
- R3: A store changes no word other than the addressed one.
- R4: A fetch presented before rising edge k loads the addressed word into the output register at edge k+1. The value is visible on `rdata_o` after that edge.
- R5: Idle and store commands leave `rdata_o` unchanged.
- R6: Command code 2'b11 is inert: it writes no word and does not change `rdata_o`.
- R7: A synchronous active-high `rst_i` clears `rdata_o` and the captured request to idle on the next edge. With CLEAR_MEM=1 it also clears every word to zero.
- R8: A fetch presented in the cycle directly after a store to the same address returns the newly stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| req_i | input | ADDR_W+DATA_W+2 | Packed request: command, address, data |
| rdata_o | output | DATA_W | Output word register, driven straight to the port |

## Verification
A corrupted word in the array stays invisible until that address is fetched. It then shows as a wrong value on `rdata_o` two edges after the fetch is presented. For this reason the bench sweeps every address after each bulk store. A wrong output-register update or hold shows on the very next cycle, because every cycle's output is compared against the last value expected to have been fetched. A store that lands on the wrong word, or on extra words, appears only when the neighbouring addresses are read back.

// File: rtl/cmdmem_pkg.sv
package cmdmem_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'b00,
    CMD_FETCH = 2'b01,
    CMD_STORE = 2'b10,
    CMD_SPARE = 2'b11
  } cmd_e;

  // A word is written only when the high command bit is set and the low bit is clear.
  function automatic logic cmd_is_store(input cmd_e c);
    return c[1] & ~c[0];
  endfunction

  // The output register loads only on the fetch code.
  function automatic logic cmd_is_fetch(input cmd_e c);
    return ~c[1] & c[0];
  endfunction

endpackage

// File: rtl/cmdmem_wdec.sv
module cmdmem_wdec #(
  parameter int ADDR_W = 4,
  localparam int WORDS = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  output logic [WORDS-1:0]  we_o
);

  for (genvar i = 0; i < WORDS; i++) begin : g_sel
    assign we_o[i] = en_i && (addr_i == ADDR_W'(i));
  end

endmodule

// File: rtl/cmdmem_rmux.sv
module cmdmem_rmux #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int WORDS = 1 << ADDR_W
) (
  input  logic [WORDS-1:0][DATA_W-1:0] words_i,
  input  logic [ADDR_W-1:0]            addr_i,
  output logic [DATA_W-1:0]            data_o
);

  assign data_o = words_i[addr_i];

endmodule

// File: rtl/cmdmem_bank.sv
module cmdmem_bank #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter bit CLEAR_MEM = 1'b1,
  localparam int WORDS    = 1 << ADDR_W
) (
  input  logic                         clk_i,
  input  logic                         rst_i,
  input  logic [WORDS-1:0]             we_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [WORDS-1:0][DATA_W-1:0] words_o
);

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    if (CLEAR_MEM) begin : g_clr
      always_ff @(posedge clk_i) begin
        if (rst_i)         words_o[i] <= '0;
        else if (we_i[i])  words_o[i] <= wdata_i;
      end
    end else begin : g_keep
      always_ff @(posedge clk_i) begin
        if (we_i[i]) words_o[i] <= wdata_i;
      end
    end
  end

endmodule

// File: rtl/cmdmem_top.sv
module cmdmem_top
  import cmdmem_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter bit CLEAR_MEM = 1'b1
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic [ADDR_W+DATA_W+1:0] req_i,
  output logic [DATA_W-1:0]        rdata_o
);

  localparam int WORDS = 1 << ADDR_W;
  localparam int REQ_W = ADDR_W + DATA_W + 2;

  // Request fields
  cmd_e              cmd_in;
  logic [ADDR_W-1:0] addr_in;
  logic [DATA_W-1:0] data_in;

  assign cmd_in  = cmd_e'(req_i[REQ_W-1 -: 2]);
  assign addr_in = req_i[DATA_W +: ADDR_W];
  assign data_in = req_i[DATA_W-1:0];

  // Captured request (part of the machine state)
  cmd_e              cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] out_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cmd_q  <= CMD_IDLE;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      cmd_q  <= cmd_in;
      addr_q <= addr_in;
      data_q <= data_in;
    end
  end

  // Named execution events
  logic                         do_store;
  logic                         do_fetch;
  logic [WORDS-1:0]             we_vec;
  logic [WORDS-1:0][DATA_W-1:0] words;
  logic [DATA_W-1:0]            rd_word;

  assign do_store = cmd_is_store(cmd_q);
  assign do_fetch = cmd_is_fetch(cmd_q);

  cmdmem_wdec #(.ADDR_W(ADDR_W)) u_wdec (
    .addr_i (addr_q),
    .en_i   (do_store),
    .we_o   (we_vec)
  );

  cmdmem_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLEAR_MEM(CLEAR_MEM)) u_bank (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .we_i    (we_vec),
    .wdata_i (data_q),
    .words_o (words)
  );

  cmdmem_rmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rmux (
    .words_i (words),
    .addr_i  (addr_q),
    .data_o  (rd_word)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i)         out_q <= '0;
    else if (do_fetch) out_q <= rd_word;
  end

  assign rdata_o = out_q;

endmodule

// File: rtl/cmdmem_chk.sv
module cmdmem_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int WORDS = 1 << ADDR_W
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic [1:0]        cmd_q,
  input logic [ADDR_W-1:0] addr_q,
  input logic [WORDS-1:0]  we_vec,
  input logic [DATA_W-1:0] rd_word,
  input logic [DATA_W-1:0] rdata_o
);

  a_r4_fetch_loads: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmd_q == 2'b01) |=> (rdata_o == $past(rd_word)));

  a_r5_out_holds: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmd_q != 2'b01) |=> $stable(rdata_o));

  a_r3_single_word: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(we_vec));

  a_r2_store_hits_addr: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmd_q == 2'b10) |-> we_vec[addr_q]);

  a_r6_spare_inert: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmd_q == 2'b11) |-> (we_vec == '0));

  a_r7_reset_clears: assert property (@(posedge clk_i)
    rst_i |=> (rdata_o == '0));

endmodule

bind cmdmem_top cmdmem_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .cmd_q   (cmd_q),
  .addr_q  (addr_q),
  .we_vec  (we_vec),
  .rd_word (rd_word),
  .rdata_o (rdata_o)
);

// File: tb/sim_cmdmem_top.sv
module sim_cmdmem_top;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NW = 1 << AW;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [AW+DW+1:0]  req = '0;
  logic [DW-1:0]     rdata;

  cmdmem_top #(.ADDR_W(AW), .DATA_W(DW), .CLEAR_MEM(1'b1)) u0 (
    .clk_i   (clk),
    .rst_i   (rst),
    .req_i   (req),
    .rdata_o (rdata)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int          due;
    logic [DW-1:0] val;
    string       tag;
  } exp_t;

  exp_t          sb[$];
  logic [DW-1:0] mdl [NW];
  logic [DW-1:0] last_exp = '0;
  int            cyc = 0;
  int            total = 0;
  int            fails = 0;
  bit            mon_en = 1'b0;
  bit            done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return DW'(a * 29 + k * 71 + 3);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: rdata=%h expected=%h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  // Driver: one request per cycle, presented 1 ns after a rising edge.
  task automatic issue(input logic [1:0] c, input int a, input logic [DW-1:0] d,
                       input string tag);
    @(posedge clk);
    #1;
    req = {c, AW'(a), d};
    if (c == 2'b10) mdl[a] = d;
    if (c == 2'b01) sb.push_back('{cyc + 2, mdl[a], tag});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) issue(2'b00, 0, '0, "R5");
  endtask

  task automatic do_reset();
    idle(3);
    @(posedge clk);
    #1;
    rst = 1'b1;
    req = '0;
    sb.push_back('{cyc + 1, '0, "R7 reset clears output"});
    for (int i = 0; i < NW; i++) mdl[i] = '0;
    @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  // Monitor: pops expected fetch results when due, else checks the output holds.
  always @(negedge clk) begin
    if (mon_en) begin
      if (sb.size() > 0 && sb[0].due == cyc) begin
        exp_t e;
        e = sb.pop_front();
        last_exp = e.val;
        check(rdata === e.val, e.tag, rdata, e.val);
      end else begin
        check(rdata === last_exp, "R5/R6 output hold", rdata, last_exp);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NW; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    mon_en = 1'b1;

    // R7: array cleared by reset
    for (int a = 0; a < NW; a++) issue(2'b01, a, '0, "R7 word cleared");
    idle(3);

    // R2 / R1: fill and read back, data and address fields distinct
    for (int a = 0; a < NW; a++) issue(2'b10, a, pat(a, 1), "R2");
    for (int a = 0; a < NW; a++) issue(2'b01, a, 8'hFF, "R2 stored word / R1 layout");
    idle(3);

    // R1: data low nibble names another address; a swapped field would hit it
    issue(2'b10, 10, 8'h35, "R1");
    issue(2'b01, 10, 8'h00, "R1 field layout addr 10");
    issue(2'b01, 5, 8'h00, "R1 field layout addr 5 untouched");
    idle(3);

    // R3: a single overwrite leaves neighbours intact
    issue(2'b10, 7, 8'hC3, "R3");
    for (int a = 0; a < NW; a++) issue(2'b01, a, '0, "R3 only addressed word changes");
    idle(3);

    // R6: code 11 must neither write nor update the output
    issue(2'b01, 2, '0, "R4 fetch before spare");
    idle(2);
    issue(2'b11, 9, 8'hEE, "R6");
    issue(2'b11, 2, 8'h11, "R6");
    idle(3);
    issue(2'b01, 9, '0, "R6 spare code wrote nothing");
    issue(2'b01, 2, '0, "R6 spare code wrote nothing");
    idle(3);

    // R8: back-to-back store then fetch of same address
    issue(2'b10, 4, 8'h5C, "R8");
    issue(2'b01, 4, '0, "R8 fetch right after store");
    issue(2'b10, 4, 8'hA7, "R8");
    issue(2'b01, 4, '0, "R8 fetch right after second store");
    idle(3);

    // R4 / R5: fetch then a run of stores and idles; output must hold
    issue(2'b01, 12, '0, "R4 fetch latency");
    for (int a = 0; a < NW; a += 3) issue(2'b10, a, pat(a, 2), "R5");
    idle(4);
    for (int a = 0; a < NW; a++) issue(2'b01, NW - 1 - a, '0, "R4 reverse sweep");
    idle(3);

    // R7: mid-run reset clears output and array
    do_reset();
    for (int a = 0; a < NW; a++) issue(2'b01, a, '0, "R7 word cleared after reset");
    idle(4);

    done = 1'b1;
    if (sb.size() != 0) begin
      total++;
      fails++;
      $display("FAIL R4: %0d expected fetch results never compared, expected 0", sb.size());
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule